// File: doc/BRIEF.md
# Soft Row Repair Entry Checker

This block sits on the device side of a DRAM and decides whether a soft repair of one row may begin. It watches decoded command strobes while a repair-mode enable is high. To arm, it must first see four mode-register writes to register 0, in order, each carrying a fixed unlock pattern on the address bus. Once armed, the next activate names the failing bank group, bank and row, which the block captures. A write to that same bank group and bank then opens an eight-beat data window, and the lanes seen across those beats decide the outcome.

The result is a one-cycle valid pulse with a two-bit status and a go flag. The status and the captured address stay on the outputs until repair mode is dropped, so the downstream repair logic can act on them. Clearing the enable returns the block to its unarmed state and wipes everything it captured. Command decoding, strobe timing recovery and the repair storage are handled elsewhere.

Top module: `rowfix_gate`

## Requirements
- R1: An unlock write is a `cmd_mrs` with `cmd_bg`=0, `cmd_ba`=0 and `cmd_addr[6:0]`=7'h7F. Its `cmd_addr[11:7]` must equal 5'b11001 for the first write, 5'b01111 for the second, 5'b10111 for the third and 5'b00111 for the fourth. `armed` goes high in the cycle after the fourth matching write and stays high while `repair_en` is high.
- R2: `cmd_addr[17:12]` has no effect on unlock matching.
- R3: While unarmed, any `cmd_mrs` that is not the expected next unlock write sends progress back to the first key. This covers a wrong pattern, `cmd_addr[6:0]` not all ones, or a nonzero `cmd_bg` or `cmd_ba`, which names another mode register.
- R4: Once armed, the first `cmd_act` loads `tgt_bg`, `tgt_ba` and `tgt_row` (all 18 address bits). These outputs show the new values in the next cycle.
- R5: After the capture, only a `cmd_wr` whose bank group and bank equal the captured ones opens the data window, whatever its address. A write to any other bank is ignored, and no result follows its beats.
- R6: The window takes the next 8 cycles with `dq_vld` high as beats 0 to 7. In the cycle after beat 7, `res_valid` pulses for one cycle. If every lane was 0 on all 8 beats, `res_code`=1 (grant) and `res_go`=1.
- R7: If every lane was 1 on beats 0 to 3, `res_code`=2 (retain abort) and `res_go`=0, whatever beats 4 to 7 carry.
- R8: Any other lane pattern gives `res_code`=3 (undefined) with `res_go`=0.
- R9: `repair_en` low clears `armed`, `res_go`, `res_code` and the target outputs at the next edge, and commands are ignored while it is low. The clear takes priority over any command or beat in the same cycle.
- R10: After synchronous reset, all outputs are 0 and `res_code`=0 (none).
- R11: After a result, `res_code`, `res_go` and the target outputs hold their values, and further commands and beats have no effect until `repair_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repair_en | input | 1 | Repair mode enable; low clears the block |
| cmd_mrs | input | 1 | Mode-register write strobe |
| cmd_act | input | 1 | Activate strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_bg | input | 2 | Bank group of the command |
| cmd_ba | input | 2 | Bank of the command |
| cmd_addr | input | ADDR_W | Address bus of the command |
| dq_vld | input | 1 | Data beat present |
| dq | input | DQ_W | Data lanes of one beat |
| armed | output | 1 | Unlock sequence complete |
| res_valid | output | 1 | One-cycle result pulse |
| res_go | output | 1 | Repair granted |
| res_code | output | 2 | 0 none, 1 grant, 2 retain abort, 3 undefined |
| tgt_bg | output | 2 | Captured bank group |
| tgt_ba | output | 2 | Captured bank |
| tgt_row | output | ADDR_W | Captured row |

## Verification
The final beat of a data window and the drop of `repair_en` can land on the same edge, so a result would be produced just as the block is being cleared. The bench forces this by presenting beat 7 with `dq_vld` high in the very cycle that `repair_en` goes low. It expects no `res_valid` pulse, `res_code` back at 0 and `armed` low one cycle later. The behavioural model in the bench applies the clear first, and it is compared against the outputs on every clock around that edge.

// File: rtl/rowfix_pkg.sv
`timescale 1ns/1ps
package rowfix_pkg;

  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_GRANT  = 2'd1,
    RES_RETAIN = 2'd2,
    RES_UNDEF  = 2'd3
  } res_code_e;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_WR   = 2'd1,
    PH_DATA = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  localparam int KEY_COUNT = 4;
  localparam int KEY_W     = 5;
  localparam int KEY_LSB   = 7;
  localparam int FIX_W     = 7;

  // Unlock pattern carried on address bits [11:7], in the order it must arrive.
  function automatic logic [KEY_W-1:0] guard_key(input int idx);
    case (idx)
      0:       guard_key = 5'b11001;
      1:       guard_key = 5'b01111;
      2:       guard_key = 5'b10111;
      default: guard_key = 5'b00111;
    endcase
  endfunction

endpackage

// File: rtl/rowfix_keyseq.sv
`timescale 1ns/1ps
module rowfix_keyseq
  import rowfix_pkg::*;
#(
  parameter int KEYS = KEY_COUNT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     mrs,
  input  logic [1:0]               bg,
  input  logic [1:0]               ba,
  input  logic [KEY_LSB+KEY_W-1:0] low_addr,
  output logic                     armed
);

  localparam int IDX_W = (KEYS > 1) ? $clog2(KEYS) : 1;

  logic [IDX_W-1:0] idx;
  logic [KEYS-1:0]  key_hit;
  logic             reg0_sel;
  logic             fixed_ok;
  logic             step_ok;

  // One comparator per key position; the current index picks the one that counts.
  for (genvar k = 0; k < KEYS; k++) begin : g_key
    assign key_hit[k] = (low_addr[KEY_LSB+KEY_W-1:KEY_LSB] == guard_key(k));
  end

  assign reg0_sel = (bg == 2'b00) && (ba == 2'b00);
  assign fixed_ok = &low_addr[FIX_W-1:0];
  assign step_ok  = reg0_sel && fixed_ok && key_hit[idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx   <= '0;
      armed <= 1'b0;
    end else if (mrs && !armed) begin
      if (step_ok) begin
        if (idx == IDX_W'(KEYS-1)) begin
          armed <= 1'b1;
          idx   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        idx <= '0;
      end
    end
  end

endmodule

// File: rtl/rowfix_burst.sv
`timescale 1ns/1ps
module rowfix_burst
  import rowfix_pkg::*;
#(
  parameter int DQ_W  = 8,
  parameter int BURST = 8,
  parameter int HEAD  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            start,
  input  logic            beat_vld,
  input  logic [DQ_W-1:0] beat,
  output logic            res_valid,
  output logic            res_go,
  res_code_e              res_code
);

  localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             all_low;
  logic             head_high;
  logic             low_next;
  logic             head_next;
  logic             in_head;
  logic             last_beat;

  // Two running flags replace a stored copy of the burst.
  assign in_head   = (cnt < CNT_W'(HEAD));
  assign low_next  = all_low & ~(|beat);
  assign head_next = head_high & (~in_head | (&beat));
  assign last_beat = (cnt == CNT_W'(BURST-1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy      <= 1'b0;
      cnt       <= '0;
      all_low   <= 1'b0;
      head_high <= 1'b0;
      res_valid <= 1'b0;
      res_go    <= 1'b0;
      res_code  <= RES_NONE;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= '0;
        all_low   <= 1'b1;
        head_high <= 1'b1;
      end else if (busy && beat_vld) begin
        if (last_beat) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_go    <= low_next;
          if (low_next)       res_code <= RES_GRANT;
          else if (head_next) res_code <= RES_RETAIN;
          else                res_code <= RES_UNDEF;
        end else begin
          cnt       <= cnt + 1'b1;
          all_low   <= low_next;
          head_high <= head_next;
        end
      end
    end
  end

endmodule

// File: rtl/rowfix_gate.sv
`timescale 1ns/1ps
module rowfix_gate
  import rowfix_pkg::*;
#(
  parameter int DQ_W       = 8,
  parameter int ADDR_W     = 18,
  parameter int BURST_LEN  = 8,
  parameter int HEAD_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repair_en,
  input  logic              cmd_mrs,
  input  logic              cmd_act,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_bg,
  input  logic [1:0]        cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              dq_vld,
  input  logic [DQ_W-1:0]   dq,
  output logic              armed,
  output logic              res_valid,
  output logic              res_go,
  output logic [1:0]        res_code,
  output logic [1:0]        tgt_bg,
  output logic [1:0]        tgt_ba,
  output logic [ADDR_W-1:0] tgt_row
);

  localparam int LOW_W = KEY_LSB + KEY_W;

  phase_e    phase;
  logic      clr;
  logic      bank_hit;
  logic      burst_start;
  res_code_e code_w;

  assign clr         = ~repair_en;
  assign bank_hit    = (cmd_bg == tgt_bg) && (cmd_ba == tgt_ba);
  assign burst_start = armed && (phase == PH_WR) && cmd_wr && bank_hit;

  rowfix_keyseq #(
    .KEYS (KEY_COUNT)
  ) keyseq_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .mrs      (cmd_mrs),
    .bg       (cmd_bg),
    .ba       (cmd_ba),
    .low_addr (cmd_addr[LOW_W-1:0]),
    .armed    (armed)
  );

  rowfix_burst #(
    .DQ_W  (DQ_W),
    .BURST (BURST_LEN),
    .HEAD  (HEAD_BEATS)
  ) burst_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .start     (burst_start),
    .beat_vld  (dq_vld),
    .beat      (dq),
    .res_valid (res_valid),
    .res_go    (res_go),
    .res_code  (code_w)
  );

  assign res_code = code_w;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase   <= PH_ACT;
      tgt_bg  <= '0;
      tgt_ba  <= '0;
      tgt_row <= '0;
    end else if (armed) begin
      case (phase)
        PH_ACT: if (cmd_act) begin
          tgt_bg  <= cmd_bg;
          tgt_ba  <= cmd_ba;
          tgt_row <= cmd_addr;
          phase   <= PH_WR;
        end
        PH_WR:   if (burst_start) phase <= PH_DATA;
        PH_DATA: if (res_valid)   phase <= PH_HOLD;
        default: phase <= PH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/rowfix_gate_sva.sv
`timescale 1ns/1ps
module rowfix_gate_sva #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              repair_en,
  input logic              armed,
  input logic              res_valid,
  input logic              res_go,
  input logic [1:0]        res_code,
  input logic [1:0]        tgt_bg,
  input logic [1:0]        tgt_ba,
  input logic [ADDR_W-1:0] tgt_row
);

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (armed && repair_en) |=> armed); // R1

  AST_RESULT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> armed); // R5

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R6

  AST_GO_MEANS_GRANT: assert property (@(posedge clk) disable iff (rst)
    res_go |-> (res_code == 2'd1)); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !repair_en |=> (!armed && !res_go && res_code == 2'd0 &&
                    tgt_bg == 2'd0 && tgt_ba == 2'd0 && tgt_row == '0)); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (repair_en && res_code != 2'd0) |=> ($stable(res_code) && $stable(tgt_row))); // R11

endmodule

bind rowfix_gate rowfix_gate_sva #(.ADDR_W(ADDR_W)) sva_i (.*);

// File: tb/rowfix_gate_tb_top.sv
`timescale 1ns/1ps
module rowfix_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DQ_W   = 8;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              repair_en = 1'b0;
  logic              cmd_mrs = 1'b0;
  logic              cmd_act = 1'b0;
  logic              cmd_wr = 1'b0;
  logic [1:0]        cmd_bg = '0;
  logic [1:0]        cmd_ba = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              dq_vld = 1'b0;
  logic [DQ_W-1:0]   dq = '0;
  logic              armed, res_valid, res_go;
  logic [1:0]        res_code, tgt_bg, tgt_ba;
  logic [ADDR_W-1:0] tgt_row;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  bit    started = 0;
  bit    finished = 0;

  rowfix_gate dut_i (
    .clk(clk), .rst(rst), .repair_en(repair_en),
    .cmd_mrs(cmd_mrs), .cmd_act(cmd_act), .cmd_wr(cmd_wr),
    .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .dq_vld(dq_vld), .dq(dq),
    .armed(armed), .res_valid(res_valid), .res_go(res_go), .res_code(res_code),
    .tgt_bg(tgt_bg), .tgt_ba(tgt_ba), .tgt_row(tgt_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int unsigned key_tab[4] = '{5'b11001, 5'b01111, 5'b10111, 5'b00111};
  int          m_kidx;
  bit          m_armed;
  int          m_ph;
  int unsigned m_bg, m_ba, m_row;
  bit          m_rv, m_go;
  int unsigned m_code;
  int unsigned beats[$];

  always @(posedge clk) begin
    started = 1;
    if (rst || !repair_en) begin
      m_kidx = 0; m_armed = 0; m_ph = 0;
      m_bg = 0; m_ba = 0; m_row = 0;
      m_rv = 0; m_go = 0; m_code = 0;
      beats.delete();
    end else begin
      m_rv = 0;
      if (!m_armed) begin
        if (cmd_mrs) begin
          if (cmd_bg == 0 && cmd_ba == 0 && cmd_addr[6:0] == 7'h7F &&
              cmd_addr[11:7] == key_tab[m_kidx][4:0]) begin
            m_kidx++;
            if (m_kidx == 4) begin m_armed = 1; m_kidx = 0; end
          end else m_kidx = 0;
        end
      end else begin
        case (m_ph)
          0: if (cmd_act) begin m_bg = cmd_bg; m_ba = cmd_ba; m_row = cmd_addr; m_ph = 1; end
          1: if (cmd_wr && cmd_bg == m_bg && cmd_ba == m_ba) begin m_ph = 2; beats.delete(); end
          2: if (dq_vld) begin
               beats.push_back(dq);
               if (beats.size() == 8) begin
                 bit lo, hi;
                 lo = 1; hi = 1;
                 foreach (beats[i]) begin
                   if (beats[i] != 0) lo = 0;
                   if (i < 4 && beats[i] != 8'hFF) hi = 0;
                 end
                 m_code = lo ? 1 : (hi ? 2 : 3);
                 m_go = lo; m_rv = 1; m_ph = 3;
               end
             end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !finished) begin
      chk(cur_req, "model armed", 32'(armed), 32'(m_armed));
      chk(cur_req, "model res_valid", 32'(res_valid), 32'(m_rv));
      chk(cur_req, "model res_go", 32'(res_go), 32'(m_go));
      chk(cur_req, "model res_code", 32'(res_code), m_code);
      chk(cur_req, "model tgt", {10'(tgt_row), 2'(tgt_bg), 2'(tgt_ba)},
          {10'(m_row), 2'(m_bg), 2'(m_ba)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic mrs(input logic [1:0] bg, input logic [1:0] ba, input logic [ADDR_W-1:0] a);
    cmd_mrs = 1; cmd_bg = bg; cmd_ba = ba; cmd_addr = a;
    @(negedge clk); cmd_mrs = 0;
  endtask
  task automatic act(input logic [1:0] bg, input logic [1:0] ba, input logic [ADDR_W-1:0] a);
    cmd_act = 1; cmd_bg = bg; cmd_ba = ba; cmd_addr = a;
    @(negedge clk); cmd_act = 0;
  endtask
  task automatic wr(input logic [1:0] bg, input logic [1:0] ba, input logic [ADDR_W-1:0] a);
    cmd_wr = 1; cmd_bg = bg; cmd_ba = ba; cmd_addr = a;
    @(negedge clk); cmd_wr = 0;
  endtask
  task automatic beat(input logic [DQ_W-1:0] d);
    dq_vld = 1; dq = d;
    @(negedge clk); dq_vld = 0;
  endtask
  function automatic logic [ADDR_W-1:0] key_addr(int k, logic [5:0] hi);
    return {hi, key_tab[k][4:0], 7'h7F};
  endfunction
  task automatic unlock(input logic [5:0] hi);
    for (int k = 0; k < 4; k++) mrs(2'b00, 2'b00, key_addr(k, hi + 6'(k * 13)));
  endtask
  task automatic drop_en();
    repair_en = 0; @(negedge clk); repair_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset armed", 32'(armed), 0);
    chk("R10", "reset code", 32'(res_code), 0);
    repair_en = 1;
    @(negedge clk);

    // R1/R2: unlock with varying bits 17:12
    cur_req = "R2";
    unlock(6'h2A);
    chk("R1", "armed after keys", 32'(armed), 1);
    // R4: capture
    cur_req = "R4";
    act(2'd2, 2'd1, 18'h25A5C);
    chk("R4", "tgt_row", 32'(tgt_row), 32'h25A5C);
    chk("R4", "tgt_bg/ba", {2'(tgt_bg), 2'(tgt_ba)}, 4'b1001);
    // R5: write to other bank ignored
    cur_req = "R5";
    wr(2'd1, 2'd1, 18'h00000);
    for (int i = 0; i < 8; i++) beat(8'h00);
    chk("R5", "no result from foreign bank", 32'(res_code), 0);
    // R6: matching write, all-low beats with a gap
    cur_req = "R6";
    wr(2'd2, 2'd1, 18'h3FFFF);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) @(negedge clk);
      beat(8'h00);
    end
    chk("R6", "res_valid", 32'(res_valid), 1);
    chk("R6", "grant code", 32'(res_code), 1);
    chk("R6", "go", 32'(res_go), 1);
    @(negedge clk);
    chk("R6", "pulse ends", 32'(res_valid), 0);
    // R11: hold after result
    cur_req = "R11";
    act(2'd0, 2'd0, 18'h11111);
    wr(2'd0, 2'd0, 18'h0);
    for (int i = 0; i < 8; i++) beat(8'hFF);
    chk("R11", "code held", 32'(res_code), 1);
    chk("R11", "row held", 32'(tgt_row), 32'h25A5C);

    // R9: disable clears, commands ignored while low
    cur_req = "R9";
    repair_en = 0;
    @(negedge clk);
    chk("R9", "armed cleared", 32'(armed), 0);
    chk("R9", "code cleared", 32'(res_code), 0);
    chk("R9", "row cleared", 32'(tgt_row), 0);
    unlock(6'h00);
    repair_en = 1;
    @(negedge clk);
    chk("R9", "keys ignored while disabled", 32'(armed), 0);

    // R3: broken sequences
    cur_req = "R3";
    mrs(0, 0, key_addr(0, 0)); mrs(0, 0, key_addr(1, 0)); mrs(0, 0, key_addr(3, 0));
    mrs(0, 0, key_addr(2, 0)); mrs(0, 0, key_addr(3, 0));
    chk("R3", "wrong order resets", 32'(armed), 0);
    mrs(0, 0, key_addr(0, 0)); mrs(0, 0, key_addr(1, 0)); mrs(0, 0, key_addr(2, 0));
    mrs(0, 1, key_addr(3, 0));
    mrs(0, 0, key_addr(3, 0));
    chk("R3", "other register resets", 32'(armed), 0);
    mrs(0, 0, key_addr(0, 0) & 18'h3FFFE); mrs(0, 0, key_addr(1, 0));
    mrs(0, 0, key_addr(2, 0)); mrs(0, 0, key_addr(3, 0));
    chk("R3", "low bits not ones", 32'(armed), 0);
    unlock(6'h3F);
    chk("R3", "clean sequence arms", 32'(armed), 1);
    // R7: retain pattern
    cur_req = "R7";
    act(2'd3, 2'd3, 18'h00ABC);
    wr(2'd3, 2'd3, 18'h12345);
    beat(8'hFF); beat(8'hFF); beat(8'hFF); beat(8'hFF);
    beat(8'h00); beat(8'h5A); beat(8'hFF); beat(8'h00);
    chk("R7", "retain code", 32'(res_code), 2);
    chk("R7", "no go", 32'(res_go), 0);

    // R8: undefined patterns
    cur_req = "R8";
    drop_en();
    unlock(6'h05);
    act(2'd0, 2'd2, 18'h3C3C3);
    wr(2'd0, 2'd2, 18'h0);
    for (int i = 0; i < 7; i++) beat(8'h00);
    beat(8'h08);
    chk("R8", "late lane high", 32'(res_code), 3);
    chk("R8", "no go", 32'(res_go), 0);
    drop_en();
    unlock(6'h19);
    act(2'd1, 2'd0, 18'h00001);
    wr(2'd1, 2'd0, 18'h0);
    beat(8'hFF); beat(8'hFF); beat(8'hFF); beat(8'hFE);
    for (int i = 0; i < 4; i++) beat(8'h00);
    chk("R8", "partial head high", 32'(res_code), 3);

    // R9: clear coincident with last beat
    cur_req = "R9";
    drop_en();
    unlock(6'h0F);
    act(2'd1, 2'd1, 18'h2AAAA);
    wr(2'd1, 2'd1, 18'h0);
    for (int i = 0; i < 7; i++) beat(8'h00);
    repair_en = 0;
    beat(8'h00);
    chk("R9", "no pulse on coincident clear", 32'(res_valid), 0);
    chk("R9", "code cleared", 32'(res_code), 0);
    chk("R9", "armed cleared", 32'(armed), 0);
    repair_en = 1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule